// File: doc/BRIEF.md
# Indirect PCI Configuration Access Port

This block gives a CPU a way to reach PCI configuration space through two registers: an address register that names the target (enable, bus, device, function, register) and a data window. A read or write of the data window becomes a single 32-bit configuration transaction on a request/acknowledge interface toward the configuration space. A read of the window holds the register bus until the configuration space answers.

Two byte-order controls are built in. A host configuration register carries a little-endian flag; when that flag is clear, every register access from the CPU is byte-reversed on the way in and on the way out. A command register carries a swap-disable flag; when it is clear and the address register selects a non-zero device/bus field, configuration data is byte-reversed in both directions as well.

Top module: `pcfg_port`

## Requirements
- R1: Register select codes are 0 = host configuration, 1 = command, 2 = configuration address, 3 = data window. After reset with the default little-endian setting, host configuration reads 0x00001000, command reads 0x00010001 and the address register reads 0x00000000.
- R2: A write to the address register stores the internal write value ANDed with 0x80FFFFFC, and a read returns the stored value.
- R3: When bit 12 of the host configuration register is clear, the write data of every register access is byte-reversed across all four bytes before use, and the read data is byte-reversed before it is returned.
- R4: A data-window write with address bit 31 set issues exactly one configuration write carrying the address register and the (possibly swapped) data; the register bus completes after the configuration acknowledge.
- R5: A data-window write with address bit 31 clear issues no configuration transaction and changes no register.
- R6: A data-window read with address bit 31 clear returns 0xFFFFFFFF and issues no configuration transaction.
- R7: A data-window read with address bit 31 set issues one configuration read and does not complete on the register bus before the configuration acknowledge; it returns the acknowledged data.
- R8: When command bit 0 is clear and address bits [23:11] are not all zero, configuration write data and read data are byte-reversed; otherwise they pass unchanged.
- R9: Each register access completes with a one-cycle reg_ready pulse, which only follows a held reg_req.
- R10: The configuration request and its write data and direction stay stable from issue until the acknowledge cycle.
- R11: Host configuration and command registers store the full 32-bit internal write value and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_req | input | 1 | Register access request, held until reg_ready |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | Register select (see R1) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_ready |
| reg_ready | output | 1 | One-cycle completion pulse |
| cfg_req | output | 1 | Configuration transaction request, held until cfg_ack |
| cfg_we | output | 1 | Configuration transaction direction, 1 = write |
| cfg_addr | output | 32 | Configuration address (address register contents) |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data, valid with cfg_ack |
| cfg_ack | input | 1 | One-cycle configuration acknowledge |

## Verification
The assertions take for granted that reg_req is held with stable select, direction and data until reg_ready, and dropped in the cycle that follows it, and that cfg_ack only arrives as a single-cycle pulse while cfg_req is high. The stimulus drives one access at a time from a task that raises reg_req, waits for reg_ready and lowers it at once, and it answers configuration requests from that same task after a chosen delay with a one-cycle acknowledge, so no acknowledge ever appears without a pending request.

// File: rtl/pcfg_pkg.sv
// Package: shared register select codes and bit positions for the
// configuration access port. Assumes 32-bit registers.
package pcfg_pkg;
    typedef enum logic [1:0] {
        SEL_HOST = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_ADDR = 2'd2,
        SEL_DATA = 2'd3
    } reg_sel_e;

    localparam logic [31:0] ADDR_KEEP_MASK = 32'h80FF_FFFC;
    localparam int HOST_LE_BIT  = 12;
    localparam int ENABLE_BIT   = 31;
    localparam int NOSWAP_BIT   = 0;
    localparam int DEV_LO       = 11;
    localparam int DEV_HI       = 23;
endpackage

// File: rtl/pcfg_bswap.sv
// Conditional byte reversal. Assumes W is a multiple of 8.
// When en is high, byte k of dout is byte (NB-1-k) of din.
module pcfg_bswap #(
    parameter int W = 32
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NB = W / 8;

    logic [W-1:0] rev;

    // One lane per byte, mirrored position.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign rev[g*8 +: 8] = din[(NB-1-g)*8 +: 8];
    end

    // Select reversed or straight data.
    assign dout = en ? rev : din;
endmodule

// File: rtl/pcfg_regfile.sv
// Holds host configuration, command and configuration address registers.
// Assumes wr_en is a single-cycle strobe and sel is never the data window
// when wr_en is high.
module pcfg_regfile
    import pcfg_pkg::*;
#(
    parameter int W       = 32,
    parameter bit LE_HOST = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] host_q,
    output logic [W-1:0] cmd_q,
    output logic [W-1:0] addr_q
);
    localparam logic [W-1:0] HOST_RST = LE_HOST ? W'(32'h0000_1000) : '0;
    localparam logic [W-1:0] CMD_RST  = LE_HOST ? W'(32'h0001_0001) : '0;
    localparam logic [W-1:0] KEEP     = W'(ADDR_KEEP_MASK);

    // Register update on reset or decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_q <= HOST_RST;
            cmd_q  <= CMD_RST;
            addr_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_HOST: host_q <= wdata;
                SEL_CMD:  cmd_q  <= wdata;
                SEL_ADDR: addr_q <= wdata & KEEP;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/pcfg_txn_fsm.sv
// Sequences register bus accesses: plain register accesses finish in one
// cycle; enabled data-window accesses issue one configuration transaction
// and wait for its acknowledge. Assumes reg_req is held until reg_ready and
// dropped right after; cfg_ack is a one-cycle pulse while cfg_req is high.
module pcfg_txn_fsm
    import pcfg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_req,
    input  logic         reg_we,
    input  reg_sel_e     reg_sel,
    input  logic         cfg_enable,
    input  logic [W-1:0] plain_rdata,
    input  logic [W-1:0] cfg_wdata_in,
    input  logic [W-1:0] cfg_rdata_in,
    input  logic         cfg_ack,
    output logic         reg_wr_en,
    output logic         reg_ready,
    output logic [W-1:0] reg_rdata,
    output logic         cfg_req,
    output logic         cfg_we,
    output logic [W-1:0] cfg_wdata
);
    typedef enum logic [1:0] {ST_IDLE, ST_CFG, ST_DONE} state_e;
    state_e state;

    logic is_data;
    assign is_data = (reg_sel == SEL_DATA);

    // Plain register writes are applied in the accepting cycle.
    assign reg_wr_en = (state == ST_IDLE) && reg_req && reg_we && !is_data;

    // Access sequencing and response capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            reg_ready <= 1'b0;
            reg_rdata <= '0;
            cfg_req   <= 1'b0;
            cfg_we    <= 1'b0;
            cfg_wdata <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (reg_req) begin
                        if (is_data && cfg_enable) begin
                            cfg_req   <= 1'b1;
                            cfg_we    <= reg_we;
                            cfg_wdata <= cfg_wdata_in;
                            state     <= ST_CFG;
                        end else begin
                            reg_ready <= 1'b1;
                            reg_rdata <= is_data ? '1 : plain_rdata;
                            state     <= ST_DONE;
                        end
                    end
                end
                ST_CFG: begin
                    if (cfg_ack) begin
                        cfg_req   <= 1'b0;
                        reg_ready <= 1'b1;
                        reg_rdata <= cfg_we ? '0 : cfg_rdata_in;
                        state     <= ST_DONE;
                    end
                end
                default: begin
                    reg_ready <= 1'b0;
                    state     <= ST_IDLE;
                end
            endcase
        end
    end

    // R10: request, direction and data stay put until acknowledged.
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_we) && $stable(cfg_wdata));

    // R9: completion is a single-cycle pulse.
    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ready |=> !reg_ready);

    // R9: completion only answers a request.
    assert_ready_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_ready) |-> $past(reg_req));
endmodule

// File: rtl/pcfg_port.sv
// Top: indirect configuration address/data port with CPU-side and
// configuration-side byte-order control. Assumes one register access at a
// time and a configuration space that acknowledges every request.
module pcfg_port
    import pcfg_pkg::*;
#(
    parameter int W       = 32,
    parameter bit LE_HOST = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_req,
    input  logic         reg_we,
    input  logic [1:0]   reg_sel,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    output logic         reg_ready,
    output logic         cfg_req,
    output logic         cfg_we,
    output logic [W-1:0] cfg_addr,
    output logic [W-1:0] cfg_wdata,
    input  logic [W-1:0] cfg_rdata,
    input  logic         cfg_ack
);
    reg_sel_e     sel;
    logic [W-1:0] host_q, cmd_q, addr_q;
    logic [W-1:0] wdata_int, wdata_dev, plain_int, plain_out;
    logic [W-1:0] crd_dev, crd_out;
    logic         cpu_swap, dev_swap, wr_en;

    assign sel      = reg_sel_e'(reg_sel);
    assign cpu_swap = !host_q[HOST_LE_BIT];
    assign dev_swap = !cmd_q[NOSWAP_BIT] && (|addr_q[DEV_HI:DEV_LO]);
    assign cfg_addr = addr_q;

    // Plain register readback mux (internal byte order).
    always_comb begin
        case (sel)
            SEL_HOST: plain_int = host_q;
            SEL_CMD:  plain_int = cmd_q;
            SEL_ADDR: plain_int = addr_q;
            default:  plain_int = '1;
        endcase
    end

    pcfg_bswap #(.W(W)) u_sw_cpu_in  (.en(cpu_swap), .din(reg_wdata), .dout(wdata_int));
    pcfg_bswap #(.W(W)) u_sw_cpu_out (.en(cpu_swap), .din(plain_int), .dout(plain_out));
    pcfg_bswap #(.W(W)) u_sw_dev_wr  (.en(dev_swap), .din(wdata_int), .dout(wdata_dev));
    pcfg_bswap #(.W(W)) u_sw_dev_rd  (.en(dev_swap), .din(cfg_rdata), .dout(crd_dev));
    pcfg_bswap #(.W(W)) u_sw_cpu_crd (.en(cpu_swap), .din(crd_dev),   .dout(crd_out));

    pcfg_regfile #(.W(W), .LE_HOST(LE_HOST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata_int),
        .host_q(host_q), .cmd_q(cmd_q), .addr_q(addr_q)
    );

    pcfg_txn_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_sel(sel), .cfg_enable(addr_q[ENABLE_BIT]),
        .plain_rdata(plain_out), .cfg_wdata_in(wdata_dev),
        .cfg_rdata_in(crd_out), .cfg_ack(cfg_ack),
        .reg_wr_en(wr_en), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata)
    );

    // R5/R6: a configuration transaction only starts with the enable bit set.
    assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_req) |-> cfg_addr[ENABLE_BIT]);

    // R7: the register bus stays held while a transaction is outstanding.
    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> reg_req);

    // R2: the address register never holds reserved bits.
    assert_addr_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(cfg_addr) |-> (cfg_addr & ~W'(ADDR_KEEP_MASK)) == '0);
endmodule

// File: tb/pcfg_port_tb.sv
// Bench: behavioural model of the three registers, a task-driven register
// bus master with an inline configuration responder, and a per-clock check
// that no configuration request appears when none is expected.
module pcfg_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        reg_ready;
    logic        cfg_req, cfg_we;
    logic [31:0] cfg_addr, cfg_wdata;
    logic [31:0] cfg_rdata = '0;
    logic        cfg_ack = 1'b0;

    int total = 0, bad = 0, cyc = 0;
    bit txn_expected = 1'b0;
    bit finished = 1'b0;

    // Model state
    logic [31:0] m_host, m_cmd, m_addr;

    always #2.5 clk = ~clk;

    pcfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_ready(reg_ready), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_ack(cfg_ack)
    );

    function automatic logic [31:0] rev4(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected<50000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Per-clock compare: R5 R6 no request when the model expects none.
    always @(negedge clk) begin
        if (rst_n && !txn_expected) check("R5/R6 idle cfg_req", {31'b0, cfg_req}, 32'h0);
    end

    // One register access with an inline configuration responder.
    task automatic access(input bit we, input logic [1:0] sel, input logic [31:0] wd,
                          input logic [31:0] crd, input int dly,
                          output logic [31:0] rd, output bit got, output bit gwe,
                          output logic [31:0] gaddr, output logic [31:0] gwd,
                          output bit ack_first);
        int cnt = 0;
        bit acked = 1'b0;
        got = 1'b0; gwe = 1'b0; gaddr = '0; gwd = '0; rd = '0; ack_first = 1'b0;
        txn_expected = (sel == 2'd3) && m_addr[31];
        @(negedge clk);
        reg_req = 1'b1; reg_we = we; reg_sel = sel; reg_wdata = wd;
        forever begin
            @(negedge clk);
            if (cfg_ack) cfg_ack = 1'b0;
            else if (cfg_req) begin
                got = 1'b1; gwe = cfg_we; gaddr = cfg_addr; gwd = cfg_wdata;
                cnt++;
                if (cnt > dly) begin cfg_ack = 1'b1; cfg_rdata = crd; acked = 1'b1; end
            end
            if (reg_ready) begin
                rd = reg_rdata; ack_first = acked;
                reg_req = 1'b0;
                break;
            end
        end
        if (cfg_ack) cfg_ack = 1'b0;
        @(negedge clk);
        check("R9 ready pulse", {31'b0, reg_ready}, 32'h0);
        txn_expected = 1'b0;
    endtask

    // Model-driven write + result compare.
    task automatic do_write(input logic [1:0] sel, input logic [31:0] wd, input int dly);
        logic [31:0] rd, ga, gw, internal;
        bit got, gwe, af, en, dsw;
        internal = m_host[12] ? wd : rev4(wd);
        en  = m_addr[31];
        dsw = !m_cmd[0] && (m_addr[23:11] != 0);
        access(1'b1, sel, wd, 32'h0, dly, rd, got, gwe, ga, gw, af);
        case (sel)
            2'd0: m_host = internal;
            2'd1: m_cmd  = internal;
            2'd2: m_addr = internal & 32'h80FF_FFFC;
            default: begin
                if (en) begin
                    check("R4 txn issued", {31'b0, got}, 32'h1);
                    check("R4 txn is write", {31'b0, gwe}, 32'h1);
                    check("R4 txn addr", ga, m_addr);
                    check("R8 write data", gw, dsw ? rev4(internal) : internal);
                    check("R4 ack before ready", {31'b0, af}, 32'h1);
                end else begin
                    check("R5 no txn", {31'b0, got}, 32'h0);
                end
            end
        endcase
    endtask

    task automatic do_read(input logic [1:0] sel, input logic [31:0] crd, input int dly,
                           input string req);
        logic [31:0] rd, ga, gw, v;
        bit got, gwe, af, en, dsw;
        en  = m_addr[31];
        dsw = !m_cmd[0] && (m_addr[23:11] != 0);
        access(1'b0, sel, 32'h0, crd, dly, rd, got, gwe, ga, gw, af);
        case (sel)
            2'd0: v = m_host;
            2'd1: v = m_cmd;
            2'd2: v = m_addr;
            default: v = en ? (dsw ? rev4(crd) : crd) : 32'hFFFF_FFFF;
        endcase
        if (!m_host[12]) v = rev4(v);
        check(req, rd, v);
        if (sel == 2'd3 && en) begin
            check("R7 txn read", {31'b0, got, gwe}, 32'h2);
            check("R7 txn addr", ga, m_addr);
            check("R7 stall until ack", {31'b0, af}, 32'h1);
        end
        if (sel == 2'd3 && !en) check("R6 no txn", {31'b0, got}, 32'h0);
    endtask

    initial begin
        m_host = 32'h0000_1000; m_cmd = 32'h0001_0001; m_addr = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        do_read(2'd0, 0, 0, "R1 host reset");
        do_read(2'd1, 0, 0, "R1 cmd reset");
        do_read(2'd2, 0, 0, "R1 addr reset");
        // R2 masking
        do_write(2'd2, 32'hFFFF_FFFF, 0);
        do_read(2'd2, 0, 0, "R2 addr masked");
        // R5 R6 disabled window
        do_write(2'd2, 32'h0000_0800, 0);
        do_write(2'd3, 32'h1122_3344, 0);
        do_read(2'd2, 0, 0, "R5 addr unchanged");
        do_read(2'd1, 0, 0, "R5 cmd unchanged");
        do_read(2'd3, 32'h5555_5555, 0, "R6 disabled read");
        // R4 R7 enabled, swap disabled by command bit 0
        do_write(2'd2, 32'h8000_0810, 0);
        do_write(2'd3, 32'hA1B2_C3D4, 2);
        do_read(2'd3, 32'h0102_0304, 3, "R7 read data");
        do_read(2'd3, 32'hCAFE_0001, 0, "R7 read zero delay");
        // R11 R8 command cleared: device swap active
        do_write(2'd1, 32'h0000_0000, 0);
        do_read(2'd1, 0, 0, "R11 cmd readback");
        do_write(2'd3, 32'hA1B2_C3D4, 1);
        do_read(2'd3, 32'h0102_0304, 2, "R8 swapped read");
        // R8 device field zero: no swap
        do_write(2'd2, 32'h8000_0004, 0);
        do_write(2'd3, 32'hDEAD_BEEF, 0);
        do_read(2'd3, 32'h0A0B_0C0D, 1, "R8 unswapped read");
        // R11 full-width command value
        do_write(2'd1, 32'h1234_5678, 0);
        do_read(2'd1, 0, 0, "R11 cmd full width");
        do_write(2'd1, 32'h0000_0000, 0);
        // R3 host byte-swap mode
        do_write(2'd0, 32'h0000_0000, 0);
        do_read(2'd0, 0, 0, "R3 host readback");
        do_write(2'd2, 32'h0408_0080, 0);
        do_read(2'd2, 0, 0, "R3 addr swapped");
        do_write(2'd3, 32'h1122_3344, 1);
        do_read(2'd3, 32'h0102_0304, 1, "R3 data read swapped");
        do_read(2'd1, 0, 0, "R3 cmd read swapped");
        // Restore little-endian mode
        do_write(2'd0, 32'h0010_0000, 0);
        do_read(2'd0, 0, 0, "R3 host restored");
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule